// File: doc/BRIEF.md
# Lane-Parallel Single-Precision Compare Unit

This block evaluates one floating-point predicate across every lane of a vector at once. Each lane carries a pair of single-precision operands. Before the compare, an optional magnitude (absolute-value) step and then an optional sign flip are applied to each operand. The 4-bit predicate code selects one of sixteen tests. The set includes the ordered relations, their negated forms, the ordered and unordered checks, and constant false and true. The per-lane outcomes form a result mask. Lanes that are off in the incoming execution mask always read zero in that mask.

A write-exec control routes the result mask onto the execution-mask output. Without it, the incoming execution mask passes through unchanged. A signal-mode select decides which signaling NaNs raise the exception flag. In quiet mode, only a signaling NaN that takes part in a real comparison raises it. In strict mode, any signaling NaN on an active lane raises it, whatever the predicate. Every result is registered one cycle after the input strobe and marked by a one-cycle output valid pulse.

Top module: `lane_fcmp_unit`

## Requirements
- R1: Predicate code 0 (`4'h0`) yields 0 and code 15 (`4'hF`) yields 1 for every active lane, NaN operands included. Codes 1..6 are LT, EQ, LE, GT, LG (not-equal) and GE. Code 7 is ordered and code 8 is unordered. Codes 9..14 are NGE, NLG, NGT, NLE, NEQ and NLT.
- R2: The relations LT, EQ, LE, GT, LG and GE follow IEEE numeric order and return 0 whenever either operand is NaN. A NaN has an all-ones exponent and a nonzero mantissa.
- R3: Each negated predicate (NGE, NLG, NGT, NLE, NEQ, NLT) is the exact inverse of its base relation, so it returns 1 when either operand is NaN.
- R4: Ordered (7) is 1 only when neither operand is NaN. Unordered (8) is 1 when at least one operand is NaN.
- R5: +0 and -0 compare equal, and neither is less than the other.
- R6: Per operand, the absolute-value bit clears the sign first and the negate bit then inverts it. With both bits set, the operand becomes minus its magnitude. The modifier bus `mods` is {abs_a, neg_a, abs_b, neg_b}, with abs_a at bit 3.
- R7: A lane whose `exec_in` bit is 0 produces a 0 in `dst_mask`.
- R8: With `wr_exec`=1, `exec_out` takes the same masked result that `dst_mask` takes.
- R9: With `wr_exec`=0, `exec_out` takes the incoming `exec_in` unchanged.
- R10: With `sig_any`=0, the `exc_flag` output is 1 only if an active lane has a signaling NaN operand and the predicate is one of codes 1..14. A signaling NaN is a NaN whose top mantissa bit (bit 22) is 0. A quiet NaN never raises the flag.
- R11: With `sig_any`=1, the `exc_flag` output is 1 whenever an active lane has a signaling NaN on either operand, for any predicate.
- R12: The outputs update on the clock edge that samples `in_valid`=1, and `out_valid` is 1 for exactly that next cycle. Without `in_valid`, `dst_mask`, `exec_out` and `exc_flag` hold their values.
- R13: Synchronous reset clears `dst_mask`, `exec_out`, `exc_flag` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| pred | input | 4 | Predicate code |
| mods | input | 4 | {abs_a, neg_a, abs_b, neg_b} modifier bits |
| sig_any | input | 1 | 1 = any signaling NaN raises the flag |
| wr_exec | input | 1 | 1 = copy the result into exec_out |
| exec_in | input | LANES | Incoming execution mask |
| src_a | input | LANES*32 | First operands, lane 0 in the low bits |
| src_b | input | LANES*32 | Second operands, lane 0 in the low bits |
| out_valid | output | 1 | One-cycle pulse marking new results |
| dst_mask | output | LANES | Registered per-lane result mask |
| exec_out | output | LANES | Registered execution mask |
| exc_flag | output | 1 | Registered signaling-NaN exception flag |

## Verification
The bench builds the unit with LANES=4. At that width a single stimulus word can be replicated onto every lane for the predicate table, and mixed per-lane patterns can be written out by hand. This puts partially active execution masks, masked-off signaling NaNs and lane-specific results within reach of direct checks at the ports. The predicate logic does not depend on the lane count, so the four-lane build covers every code, NaN rule, zero-sign case and modifier ordering. At the default width, only the wide reductions would differ.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int FP_W  = 1 + EXP_W + MAN_W;

  typedef enum logic [3:0] {
    PR_FALSE = 4'd0,
    PR_LT    = 4'd1,
    PR_EQ    = 4'd2,
    PR_LE    = 4'd3,
    PR_GT    = 4'd4,
    PR_LG    = 4'd5,
    PR_GE    = 4'd6,
    PR_ORD   = 4'd7,
    PR_UNO   = 4'd8,
    PR_NGE   = 4'd9,
    PR_NLG   = 4'd10,
    PR_NGT   = 4'd11,
    PR_NLE   = 4'd12,
    PR_NEQ   = 4'd13,
    PR_NLT   = 4'd14,
    PR_TRUE  = 4'd15
  } pred_e;

  typedef struct packed {
    logic abs_en;
    logic neg_en;
  } fmod_t;
endpackage

// File: rtl/fcmp_modify.sv
module fcmp_modify #(
  parameter int FP_W = fcmp_pkg::FP_W
) (
  input  logic [FP_W-1:0] din,
  input  fcmp_pkg::fmod_t mod,
  output logic [FP_W-1:0] dout
);
  logic mag_sign;

  always_comb begin
    // magnitude first, then the sign flip
    mag_sign = mod.abs_en ? 1'b0 : din[FP_W-1];
    dout     = {mag_sign ^ mod.neg_en, din[FP_W-2:0]};
  end
endmodule

// File: rtl/fcmp_lane.sv
module fcmp_lane
  import fcmp_pkg::*;
#(
  parameter int EXP_W = fcmp_pkg::EXP_W,
  parameter int MAN_W = fcmp_pkg::MAN_W
) (
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  input  logic [3:0]           pred,
  output logic                 hit,
  output logic                 snan_seen
);
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int MAG_W = FP_W - 1;

  logic             sa, sb;
  logic [MAG_W-1:0] ma, mb;
  logic             nan_a, nan_b, snan_a, snan_b, zero_a, zero_b;
  logic             ordered, both_zero, lt_raw, eq_raw, gt_raw;
  logic             lt_o, eq_o, gt_o;

  always_comb begin
    sa     = op_a[FP_W-1];
    sb     = op_b[FP_W-1];
    ma     = op_a[MAG_W-1:0];
    mb     = op_b[MAG_W-1:0];
    nan_a  = (&op_a[FP_W-2:MAN_W]) && (|op_a[MAN_W-1:0]);
    nan_b  = (&op_b[FP_W-2:MAN_W]) && (|op_b[MAN_W-1:0]);
    snan_a = nan_a && !op_a[MAN_W-1];
    snan_b = nan_b && !op_b[MAN_W-1];
    zero_a = (ma == '0);
    zero_b = (mb == '0);

    ordered   = !nan_a && !nan_b;
    both_zero = zero_a && zero_b;
    eq_raw    = both_zero || (op_a == op_b);
    if (both_zero)     lt_raw = 1'b0;
    else if (sa != sb) lt_raw = sa;
    else if (sa)       lt_raw = (mb < ma);
    else               lt_raw = (ma < mb);
    // one magnitude comparator serves both directions
    gt_raw = !lt_raw && !eq_raw;

    lt_o = ordered && lt_raw;
    eq_o = ordered && eq_raw;
    gt_o = ordered && gt_raw;

    snan_seen = snan_a || snan_b;

    unique case (pred_e'(pred))
      PR_FALSE: hit = 1'b0;
      PR_LT:    hit = lt_o;
      PR_EQ:    hit = eq_o;
      PR_LE:    hit = lt_o || eq_o;
      PR_GT:    hit = gt_o;
      PR_LG:    hit = lt_o || gt_o;
      PR_GE:    hit = gt_o || eq_o;
      PR_ORD:   hit = ordered;
      PR_UNO:   hit = !ordered;
      PR_NGE:   hit = !(gt_o || eq_o);
      PR_NLG:   hit = !(lt_o || gt_o);
      PR_NGT:   hit = !gt_o;
      PR_NLE:   hit = !(lt_o || eq_o);
      PR_NEQ:   hit = !eq_o;
      PR_NLT:   hit = !lt_o;
      PR_TRUE:  hit = 1'b1;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/lane_fcmp_unit.sv
module lane_fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int LANES = 64,
  parameter int EXP_W = fcmp_pkg::EXP_W,
  parameter int MAN_W = fcmp_pkg::MAN_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [3:0]                   pred,
  input  logic [3:0]                   mods,
  input  logic                         sig_any,
  input  logic                         wr_exec,
  input  logic [LANES-1:0]             exec_in,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] src_a,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] src_b,
  output logic                         out_valid,
  output logic [LANES-1:0]             dst_mask,
  output logic [LANES-1:0]             exec_out,
  output logic                         exc_flag
);
  localparam int FP_W = 1 + EXP_W + MAN_W;

  fmod_t            mod_a, mod_b;
  logic [LANES-1:0] lane_hit, lane_snan, masked_hit;
  logic             cmp_pred, flag_next;

  assign mod_a = '{abs_en: mods[3], neg_en: mods[2]};
  assign mod_b = '{abs_en: mods[1], neg_en: mods[0]};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [FP_W-1:0] a_mod, b_mod;

    fcmp_modify #(.FP_W(FP_W)) u_mod_a (
      .din (src_a[g*FP_W +: FP_W]),
      .mod (mod_a),
      .dout(a_mod)
    );

    fcmp_modify #(.FP_W(FP_W)) u_mod_b (
      .din (src_b[g*FP_W +: FP_W]),
      .mod (mod_b),
      .dout(b_mod)
    );

    fcmp_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
      .op_a     (a_mod),
      .op_b     (b_mod),
      .pred     (pred),
      .hit      (lane_hit[g]),
      .snan_seen(lane_snan[g])
    );
  end

  always_comb begin
    masked_hit = lane_hit & exec_in;
    cmp_pred   = (pred != PR_FALSE) && (pred != PR_TRUE);
    flag_next  = (|(lane_snan & exec_in)) && (sig_any || cmp_pred);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst_mask  <= '0;
      exec_out  <= '0;
      exc_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_mask <= masked_hit;
        exec_out <= wr_exec ? masked_hit : exec_in;
        exc_flag <= flag_next;
      end
    end
  end
endmodule

// File: rtl/fcmp_checker.sv
module fcmp_checker #(
  parameter int LANES = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [3:0]       pred,
  input logic             sig_any,
  input logic             wr_exec,
  input logic [LANES-1:0] exec_in,
  input logic             out_valid,
  input logic [LANES-1:0] dst_mask,
  input logic [LANES-1:0] exec_out,
  input logic             exc_flag
);
  AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((dst_mask & ~$past(exec_in)) == '0)); // R7

  AST_EXEC_COPY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(wr_exec)) |-> (exec_out == dst_mask)); // R8

  AST_EXEC_PASS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(wr_exec)) |-> (exec_out == $past(exec_in))); // R9

  AST_QUIET_CONST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(sig_any) && (($past(pred) == 4'd0) || ($past(pred) == 4'd15)))
      |-> !exc_flag); // R10

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R12

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R12

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(dst_mask) && $stable(exec_out) && $stable(exc_flag))); // R12
endmodule

bind lane_fcmp_unit fcmp_checker #(.LANES(LANES)) u_fcmp_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .pred     (pred),
  .sig_any  (sig_any),
  .wr_exec  (wr_exec),
  .exec_in  (exec_in),
  .out_valid(out_valid),
  .dst_mask (dst_mask),
  .exec_out (exec_out),
  .exc_flag (exc_flag)
);

// File: tb/sim_lane_fcmp_unit.sv
`timescale 1ns/1ps
module sim_lane_fcmp_unit;
  localparam int LANES = 4;
  localparam int FP_W  = 32;
  localparam int NV    = 30;

  localparam logic [31:0] P1   = 32'h3F80_0000;
  localparam logic [31:0] P2   = 32'h4000_0000;
  localparam logic [31:0] M1   = 32'hBF80_0000;
  localparam logic [31:0] M2   = 32'hC000_0000;
  localparam logic [31:0] PZ   = 32'h0000_0000;
  localparam logic [31:0] MZ   = 32'h8000_0000;
  localparam logic [31:0] QN   = 32'h7FC0_0000;
  localparam logic [31:0] SN   = 32'h7F80_0001;
  localparam logic [31:0] PINF = 32'h7F80_0000;
  localparam logic [31:0] MINF = 32'hFF80_0000;
  localparam logic [31:0] DEN  = 32'h0000_0001;

  // {pred, a, b, mods{abs_a,neg_a,abs_b,neg_b}, expected}
  localparam logic [72:0] VEC [NV] = '{
    {4'd0,  P1,   P2,   4'b0000, 1'b0},  // R1 false
    {4'd15, QN,   QN,   4'b0000, 1'b1},  // R1 true with NaN
    {4'd1,  P1,   P2,   4'b0000, 1'b1},  // R2 LT
    {4'd1,  P2,   P1,   4'b0000, 1'b0},  // R2
    {4'd1,  M1,   P1,   4'b0000, 1'b1},  // R2 mixed sign
    {4'd1,  M2,   M1,   4'b0000, 1'b1},  // R2 both negative
    {4'd4,  PINF, P2,   4'b0000, 1'b1},  // R2 GT
    {4'd3,  P1,   P1,   4'b0000, 1'b1},  // R2 LE
    {4'd6,  MINF, P1,   4'b0000, 1'b0},  // R2 GE
    {4'd5,  P1,   P2,   4'b0000, 1'b1},  // R2 LG
    {4'd1,  QN,   P1,   4'b0000, 1'b0},  // R2 NaN false
    {4'd2,  QN,   QN,   4'b0000, 1'b0},  // R2 NaN not equal
    {4'd1,  PZ,   DEN,  4'b0000, 1'b1},  // R2 denormal
    {4'd2,  PZ,   MZ,   4'b0000, 1'b1},  // R5 zeros equal
    {4'd1,  MZ,   PZ,   4'b0000, 1'b0},  // R5 not less
    {4'd9,  QN,   P1,   4'b0000, 1'b1},  // R3 NGE NaN
    {4'd9,  P1,   P2,   4'b0000, 1'b1},  // R3 NGE
    {4'd9,  P2,   P1,   4'b0000, 1'b0},  // R3
    {4'd13, QN,   QN,   4'b0000, 1'b1},  // R3 NEQ NaN
    {4'd10, P1,   P1,   4'b0000, 1'b1},  // R3 NLG
    {4'd10, P1,   P2,   4'b0000, 1'b0},  // R3
    {4'd14, P1,   QN,   4'b0000, 1'b1},  // R3 NLT NaN
    {4'd7,  P1,   QN,   4'b0000, 1'b0},  // R4 ordered
    {4'd7,  P1,   P2,   4'b0000, 1'b1},  // R4
    {4'd8,  SN,   P1,   4'b0000, 1'b1},  // R4 unordered
    {4'd8,  P1,   P2,   4'b0000, 1'b0},  // R4
    {4'd2,  M1,   P1,   4'b1000, 1'b1},  // R6 abs only
    {4'd2,  P1,   M1,   4'b1100, 1'b1},  // R6 abs then neg
    {4'd1,  M1,   M1,   4'b0001, 1'b1},  // R6 neg only
    {4'd4,  PZ,   P2,   4'b0011, 1'b1}   // R6 -|b|
  };

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  in_valid = 1'b0;
  logic [3:0]            pred = '0;
  logic [3:0]            mods = '0;
  logic                  sig_any = 1'b0;
  logic                  wr_exec = 1'b0;
  logic [LANES-1:0]      exec_in = '0;
  logic [LANES*FP_W-1:0] src_a = '0;
  logic [LANES*FP_W-1:0] src_b = '0;
  logic                  out_valid;
  logic [LANES-1:0]      dst_mask;
  logic [LANES-1:0]      exec_out;
  logic                  exc_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lane_fcmp_unit #(.LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pred(pred), .mods(mods),
    .sig_any(sig_any), .wr_exec(wr_exec), .exec_in(exec_in),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .dst_mask(dst_mask), .exec_out(exec_out), .exc_flag(exc_flag)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic issue(input logic [3:0] p, input logic [3:0] m, input logic s,
                       input logic w, input logic [LANES-1:0] ex,
                       input logic [LANES*FP_W-1:0] a, input logic [LANES*FP_W-1:0] b);
    @(negedge clk);
    pred = p; mods = m; sig_any = s; wr_exec = w; exec_in = ex;
    src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13 reset dst_mask", 64'(dst_mask), 64'h0);
    check("R13 reset exec_out", 64'(exec_out), 64'h0);
    check("R13 reset exc_flag", 64'(exc_flag), 64'h0);
    check("R13 reset out_valid", 64'(out_valid), 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][72:69], VEC[i][4:1], 1'b0, 1'b0, {LANES{1'b1}},
            {LANES{VEC[i][68:37]}}, {LANES{VEC[i][36:5]}});
      check($sformatf("R1-table entry %0d", i), 64'(dst_mask),
            64'({LANES{VEC[i][0]}}));
    end

    // R7 inactive lanes forced to zero
    issue(4'd15, 4'b0000, 1'b0, 1'b0, 4'b0101, {4{P1}}, {4{P1}});
    check("R7 inactive lanes zero", 64'(dst_mask), 64'h5);

    // R8 write-exec copies per-lane result
    issue(4'd1, 4'b0000, 1'b0, 1'b1, 4'b1111, {P2, P1, P2, P1}, {4{P2}});
    check("R8 dst_mask lanes", 64'(dst_mask), 64'h5);
    check("R8 exec_out copy", 64'(exec_out), 64'h5);

    // R9 pass-through of execution mask
    issue(4'd15, 4'b0000, 1'b0, 1'b0, 4'b1011, {4{P1}}, {4{P1}});
    check("R9 exec_out passthrough", 64'(exec_out), 64'hB);
    check("R9 dst_mask masked", 64'(dst_mask), 64'hB);
    check("R12 out_valid pulse", 64'(out_valid), 64'h1);
    @(negedge clk);
    check("R12 out_valid drops", 64'(out_valid), 64'h0);
    src_a = {4{QN}}; pred = 4'd0; exec_in = 4'b0000;
    @(negedge clk);
    check("R12 dst_mask holds", 64'(dst_mask), 64'hB);
    check("R12 exec_out holds", 64'(exec_out), 64'hB);

    // R10 quiet mode flag
    issue(4'd1, 4'b0000, 1'b0, 1'b0, 4'b1111, {P1, P1, P1, SN}, {4{P1}});
    check("R10 sNaN in LT flags", 64'(exc_flag), 64'h1);
    issue(4'd1, 4'b0000, 1'b0, 1'b0, 4'b1111, {4{QN}}, {4{P1}});
    check("R10 qNaN no flag", 64'(exc_flag), 64'h0);
    issue(4'd15, 4'b0000, 1'b0, 1'b0, 4'b1111, {4{SN}}, {4{SN}});
    check("R10 sNaN under true no flag", 64'(exc_flag), 64'h0);
    issue(4'd2, 4'b0000, 1'b0, 1'b0, 4'b1110, {P1, P1, P1, SN}, {4{P1}});
    check("R10 sNaN on inactive lane", 64'(exc_flag), 64'h0);
    issue(4'd14, 4'b0000, 1'b0, 1'b0, 4'b1111, {4{P1}}, {P1, SN, P1, P1});
    check("R10 sNaN in b flags", 64'(exc_flag), 64'h1);

    // R11 strict mode flag
    issue(4'd0, 4'b0000, 1'b1, 1'b0, 4'b1111, {4{P1}}, {P1, P1, SN, P1});
    check("R11 sNaN under false flags", 64'(exc_flag), 64'h1);
    issue(4'd15, 4'b0000, 1'b1, 1'b0, 4'b1111, {4{QN}}, {4{QN}});
    check("R11 qNaN no flag", 64'(exc_flag), 64'h0);
    issue(4'd15, 4'b0000, 1'b1, 1'b0, 4'b1111, {SN, P1, P1, P1}, {4{P1}});
    check("R11 sNaN under true flags", 64'(exc_flag), 64'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule